// File: doc/BRIEF.md
# Double-Rate Serial PCM Port

This block is the digital side of a 2B+D serial voice port in which the data clock runs at twice the bit rate, so every serial bit occupies two data-clock periods. In each 8 kHz frame it sends one 8-bit word, MSB first, and receives one 8-bit word. Both directions use the same B slot. A channel-select pin picks the first slot, or a second slot that begins 16 data-clock periods later. A frame opens on the first data-clock rising edge at which the frame sync is high.

The system clock oversamples every pin-side input (data clock, frame sync, serial data, channel select and the alternate receive clock). The block enables itself when the alternate receive clock pin has stayed low through two frame-sync rising edges in a row. It disables itself again at the first frame-sync rising edge after that pin has been seen high. The word to send is taken from a parallel input when the frame opens. The received word appears on a parallel output together with a one-cycle strobe. The serial output comes with an enable that the pad logic uses to drive the pin or float it.

Top module: `gci_pcm_port`

## Requirements
- R1: The mode flag sets at a frame-sync rising edge once the alternate clock input has been low at two consecutive frame-sync rising edges and high at no time between them. After a single such edge the flag stays low.
- R2: If the alternate clock input is seen high at any time since the previous frame-sync rising edge, the mode flag clears at the next frame-sync rising edge. The current frame finishes its transfer normally.
- R3: A frame opens on the first data-clock rising edge at which the frame sync is high. That edge is index 0, and each later data-clock rising edge adds one to the index.
- R4: The slot base b is 0 when the channel select is low and 16 when it is high. The channel select is sampled when the frame opens.
- R5: The transmit word is sampled when the frame opens. Bit 7-i, MSB first, is launched at rising edge b+2i for i = 0..7 and holds for two data-clock periods. Changes to the parallel word later in the frame have no effect.
- R6: The output enable is high from rising edge b until the data-clock falling edge that follows rising edge b+15, which is 15.5 data-clock periods. The serial output is low whenever the enable is low.
- R7: Receive bit 7-i is captured at rising edge b+1+2i. After the capture at b+15, the word appears on the parallel output with a valid strobe that lasts one system clock, once per frame.
- R8: While the mode flag is low, the output enable and the valid strobe stay low.
- R9: Without a frame sync the edge index saturates at a limit of at least 32. The output enable and the valid strobe then stay low, even while the data clock runs and the mode flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples all pin inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcl_i | input | 1 | Data clock, twice the bit rate |
| fsc_i | input | 1 | Frame sync |
| din_i | input | 1 | Serial receive data |
| chan_sel_i | input | 1 | Slot select: 0 first slot, 1 second slot |
| alt_clk_i | input | 1 | Alternate receive clock pin used for mode detection |
| tx_word_i | input | 8 | Parallel word to transmit |
| dout_o | output | 1 | Serial transmit data |
| dout_en_o | output | 1 | Drive enable for the serial output pad |
| rx_word_o | output | 8 | Last word received |
| rx_valid_o | output | 1 | One-cycle strobe when rx_word_o updates |
| mode_o | output | 1 | Mode flag, set while the port is active |

## Verification
Three situations are hard to reach from the ports. The first is the mode flag dropping while a transfer is still in progress. The second is the frame that follows, which must not transfer. The third is the two-sync recount needed before transfers resume. The bench toggles the alternate clock pin in the middle of a working frame. It then runs three more synced frames and expects the slot to complete, then stay silent, then stay silent again, then come back. A second hard case is a data clock that keeps running with the sync withheld for two frame lengths. That run drives the edge index into saturation, and the bench checks that the enable stays low throughout. Throughout, the bench drives deliberately wrong data on the receive line at every non-capture edge and changes the parallel transmit word after the frame opens, so that any timing slip or late sampling shows up in the words.

// File: rtl/gci_pcm_pkg.sv
package gci_pcm_pkg;
  // bits per PCM word
  localparam int unsigned WORD_BITS    = 8;
  // data-clock periods between the start of slot one and slot two
  localparam int unsigned SLOT2_OFFSET = 16;
  // frame-sync edges with the alternate clock held low before the mode engages
  localparam int unsigned MODE_SYNCS   = 2;
  // last edge offset inside a slot (capture of the LSB)
  localparam int unsigned LAST_OFF     = 2 * WORD_BITS - 1;
endpackage

// File: rtl/gci_in_sync.sv
module gci_in_sync #(
  parameter int unsigned N      = 5,
  parameter int unsigned N_EDGE = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pin_i,
  output logic [N-1:0]      lvl_o,
  output logic [N_EDGE-1:0] rise_o,
  output logic [N_EDGE-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin_i[i]};
    end
    assign lvl_o[i] = chain_q[STAGES-1];
  end

  for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_o[e];
    end
    assign rise_o[e] =  lvl_o[e] & ~prev_q;
    assign fall_o[e] = ~lvl_o[e] &  prev_q;
  end
endmodule

// File: rtl/gci_mode_det.sv
module gci_mode_det
  import gci_pcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fsc_rise_i,
  input  logic alt_lvl_i,
  output logic mode_o
);
  localparam int unsigned CW = $clog2(MODE_SYNCS + 1);
  localparam logic [CW-1:0] CMAX = CW'(MODE_SYNCS);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          seen_q, seen_n;
  logic          mode_q, mode_n;

  always_comb begin
    cnt_n  = cnt_q;
    mode_n = mode_q;
    seen_n = seen_q | alt_lvl_i;
    if (fsc_rise_i) begin
      seen_n = 1'b0;
      if (seen_q | alt_lvl_i) begin
        cnt_n  = '0;
        mode_n = 1'b0;
      end else begin
        if (cnt_q != CMAX) cnt_n = cnt_q + 1'b1;
        mode_n = (cnt_n == CMAX);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      seen_q <= seen_n;
      mode_q <= mode_n;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/gci_slot_timer.sv
module gci_slot_timer #(
  parameter int unsigned LIMIT = 1023,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dcl_rise_i,
  input  logic             fsc_lvl_i,
  output logic             frame_start_o,
  output logic [CNT_W-1:0] idx_next_o,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] CLIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] idx_q;
  logic             fsc_at_rise_q;

  assign frame_start_o = dcl_rise_i & fsc_lvl_i & ~fsc_at_rise_q;

  always_comb begin
    if (frame_start_o)      idx_next_o = '0;
    else if (idx_q == CLIM) idx_next_o = CLIM;
    else                    idx_next_o = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q         <= CLIM;
      fsc_at_rise_q <= 1'b0;
    end else if (dcl_rise_i) begin
      idx_q         <= idx_next_o;
      fsc_at_rise_q <= fsc_lvl_i;
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/gci_lanes.sv
module gci_lanes
  import gci_pcm_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_i,
  input  logic                 dcl_rise_i,
  input  logic                 dcl_fall_i,
  input  logic                 frame_start_i,
  input  logic [CNT_W-1:0]     idx_next_i,
  input  logic [CNT_W-1:0]     idx_i,
  input  logic                 chan_i,
  input  logic                 din_i,
  input  logic [WORD_BITS-1:0] tx_word_i,
  output logic                 dout_o,
  output logic                 dout_en_o,
  output logic [WORD_BITS-1:0] rx_word_o,
  output logic                 rx_valid_o
);
  localparam int unsigned BI_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] B2   = CNT_W'(SLOT2_OFFSET);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LAST_OFF);
  localparam logic [BI_W-1:0]  TOPB = BI_W'(WORD_BITS - 1);

  logic                 chan_q, chan_eff;
  logic [WORD_BITS-1:0] word_q, word_eff;
  logic [CNT_W-1:0]     off_rise, off_fall;
  logic [BI_W-1:0]      bit_i;
  logic                 tx_slot, rx_slot;

  logic                 dout_q, dout_n, en_q, en_n, val_n;
  logic [WORD_BITS-1:0] sh_q, sh_n, rxw_q, rxw_n;

  assign chan_eff = frame_start_i ? chan_i    : chan_q;
  assign word_eff = frame_start_i ? tx_word_i : word_q;
  assign off_rise = idx_next_i - (chan_eff ? B2 : '0);
  assign off_fall = idx_i      - (chan_q   ? B2 : '0);
  assign bit_i    = off_rise[BI_W:1];
  assign tx_slot  = (off_rise < LAST) && !off_rise[0];
  assign rx_slot  = (off_rise <= LAST) && off_rise[0];

  always_comb begin
    dout_n = dout_q;
    en_n   = en_q;
    sh_n   = sh_q;
    rxw_n  = rxw_q;
    val_n  = 1'b0;
    if (!mode_i) begin
      dout_n = 1'b0;
      en_n   = 1'b0;
    end else if (dcl_rise_i) begin
      if (tx_slot) begin
        dout_n = word_eff[TOPB - bit_i];
        en_n   = 1'b1;
      end
      if (rx_slot) begin
        sh_n = {sh_q[WORD_BITS-2:0], din_i};
        if (off_rise == LAST) begin
          rxw_n = sh_n;
          val_n = 1'b1;
        end
      end
    end else if (dcl_fall_i && en_q && off_fall == LAST) begin
      dout_n = 1'b0;
      en_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q     <= 1'b0;
      word_q     <= '0;
      dout_q     <= 1'b0;
      en_q       <= 1'b0;
      sh_q       <= '0;
      rxw_q      <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      if (frame_start_i) begin
        chan_q <= chan_i;
        word_q <= tx_word_i;
      end
      dout_q     <= dout_n;
      en_q       <= en_n;
      sh_q       <= sh_n;
      rxw_q      <= rxw_n;
      rx_valid_o <= val_n;
    end
  end

  assign dout_o    = dout_q;
  assign dout_en_o = en_q;
  assign rx_word_o = rxw_q;
endmodule

// File: rtl/gci_pcm_port.sv
module gci_pcm_port
  import gci_pcm_pkg::*;
#(
  parameter int unsigned EDGE_LIMIT  = 1023,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dcl_i,
  input  logic                 fsc_i,
  input  logic                 din_i,
  input  logic                 chan_sel_i,
  input  logic                 alt_clk_i,
  input  logic [WORD_BITS-1:0] tx_word_i,
  output logic                 dout_o,
  output logic                 dout_en_o,
  output logic [WORD_BITS-1:0] rx_word_o,
  output logic                 rx_valid_o,
  output logic                 mode_o
);
  localparam int unsigned CNT_W = $clog2(EDGE_LIMIT + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // pin index order: dcl, fsc (edges needed), alt, din, chan
  logic [4:0] pin_lvl;
  logic [1:0] pin_rise, pin_fall;
  gci_in_sync #(.N(5), .N_EDGE(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  ({chan_sel_i, din_i, alt_clk_i, fsc_i, dcl_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  logic dcl_rise, dcl_fall, fsc_rise, unused_fsc_fall, unused_dcl_lvl;
  assign dcl_rise        = pin_rise[0];
  assign dcl_fall        = pin_fall[0];
  assign fsc_rise        = pin_rise[1];
  assign unused_fsc_fall = pin_fall[1];
  assign unused_dcl_lvl  = pin_lvl[0];

  logic mode_active;
  gci_mode_det u_mode (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fsc_rise_i (fsc_rise),
    .alt_lvl_i  (pin_lvl[2]),
    .mode_o     (mode_active)
  );

  logic             frame_start;
  logic [CNT_W-1:0] idx_next, idx_cur;
  gci_slot_timer #(.LIMIT(EDGE_LIMIT), .CNT_W(CNT_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .dcl_rise_i    (dcl_rise),
    .fsc_lvl_i     (pin_lvl[1]),
    .frame_start_o (frame_start),
    .idx_next_o    (idx_next),
    .idx_o         (idx_cur)
  );

  gci_lanes #(.CNT_W(CNT_W)) u_lanes (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .mode_i        (mode_active),
    .dcl_rise_i    (dcl_rise),
    .dcl_fall_i    (dcl_fall),
    .frame_start_i (frame_start),
    .idx_next_i    (idx_next),
    .idx_i         (idx_cur),
    .chan_i        (pin_lvl[4]),
    .din_i         (pin_lvl[3]),
    .tx_word_i     (tx_word_i),
    .dout_o        (dout_o),
    .dout_en_o     (dout_en_o),
    .rx_word_o     (rx_word_o),
    .rx_valid_o    (rx_valid_o)
  );

  assign mode_o = mode_active;
endmodule

// File: rtl/gci_pcm_checks.sv
module gci_pcm_checks (
  input logic clk,
  input logic rst_n,
  input logic dout,
  input logic dout_en,
  input logic rx_valid,
  input logic mode_active,
  input logic dcl_rise,
  input logic dcl_fall,
  input logic fsc_rise
);
  // R8: no drive and no strobe without the mode
  assert_en_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> mode_active);
  assert_valid_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> mode_active);

  // R7: strobe lasts one cycle
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: enable opens only on a data-clock rise, closes on a fall or a mode drop
  assert_en_rise_on_dcl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> $past(dcl_rise));
  assert_en_fall_on_dcl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_en) |-> ($past(dcl_fall) || !$past(mode_active)));
  assert_dout_low_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> !dout);

  // R5: output holds between data-clock rises
  assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && $past(dout_en) && !$past(dcl_rise)) |-> $stable(dout));

  // R1: mode engages only at a frame-sync rise
  assert_mode_on_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_active) |-> $past(fsc_rise));
  // R2: mode drops only at a frame-sync rise
  assert_mode_off_on_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_active) |-> $past(fsc_rise));
endmodule

bind gci_pcm_port gci_pcm_checks u_checks (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .dout        (dout_o),
  .dout_en     (dout_en_o),
  .rx_valid    (rx_valid_o),
  .mode_active (mode_active),
  .dcl_rise    (dcl_rise),
  .dcl_fall    (dcl_fall),
  .fsc_rise    (fsc_rise)
);

// File: tb/tb_gci_pcm_port.sv
`timescale 1ns/1ps
module tb_gci_pcm_port;
  localparam int FRAME_EDGES = 40;
  localparam int HALF        = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dcl, fsc, din, chan, alt;
  logic [7:0] tx_word;
  logic       dout, dout_en, rx_valid, mode;
  logic [7:0] rx_word;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  always #2.5 clk = ~clk;

  gci_pcm_port #(.EDGE_LIMIT(63)) dut (
    .clk(clk), .rst_n(rst_n), .dcl_i(dcl), .fsc_i(fsc), .din_i(din),
    .chan_sel_i(chan), .alt_clk_i(alt), .tx_word_i(tx_word),
    .dout_o(dout), .dout_en_o(dout_en), .rx_word_o(rx_word),
    .rx_valid_o(rx_valid), .mode_o(mode)
  );

  always @(posedge clk) begin
    if (rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= rx_word;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame of FRAME_EDGES data-clock rises, with checks in every phase
  task automatic run_frame(input bit with_sync, input bit ch, input logic [7:0] txw,
                           input logic [7:0] rxw, input bit exp_mode,
                           input bit exp_xfer, input bit toggle_alt);
    int b = ch ? 16 : 0;
    int rx_start = rx_cnt;
    chan    = ch;
    tx_word = txw;
    for (int k = 0; k < FRAME_EDGES; k++) begin
      int off = k - b;
      bit e_en;
      bit e_do;
      if (k == 0 && with_sync) begin
        fsc = 1'b1;
        wait_clk(5);
      end
      dcl = 1'b1;
      if (k == 3) tx_word = ~txw; // R5: late change must be ignored
      wait_clk(HALF / 2);
      // high phase after rise k
      e_en = exp_xfer && off >= 0 && off <= 15;
      e_do = e_en ? txw[7 - off / 2] : 1'b0;
      if (k == 0) check(mode == exp_mode, "R1/R2 mode flag", mode, exp_mode);
      check(dout_en == e_en, "R6 enable high phase (R4 slot, R9)", dout_en, e_en);
      check(dout == e_do, "R5 dout high phase", dout, e_do);
      wait_clk(HALF / 2);
      dcl = 1'b0;
      if (k == 1) fsc = 1'b0;
      if (toggle_alt && k == 20) alt = 1'b1;
      if (toggle_alt && k == 22) alt = 1'b0;
      if (((k + 1 - b) >= 1) && ((k + 1 - b) <= 15) && ((k + 1 - b) % 2 == 1))
        din = rxw[7 - (k + 1 - b) / 2];
      else
        din = ~rxw[k % 8]; // wrong data outside capture points
      wait_clk(HALF / 2);
      e_en = exp_xfer && off >= 0 && off <= 14;
      e_do = e_en ? txw[7 - off / 2] : 1'b0;
      check(dout_en == e_en, "R6 enable low phase", dout_en, e_en);
      check(dout == e_do, "R6 dout low phase", dout, e_do);
      wait_clk(HALF / 2);
    end
    check((rx_cnt - rx_start) == (exp_xfer ? 1 : 0), "R7/R8 valid strobes per frame",
          rx_cnt - rx_start, exp_xfer ? 1 : 0);
    if (exp_xfer) check(rx_last == rxw, "R7 received word", rx_last, rxw);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; dcl = 0; fsc = 0; din = 0; chan = 0; alt = 0; tx_word = 8'h00;
    wait_clk(4);
    check(dout_en == 1'b0, "R8 reset enable", dout_en, 0);
    check(dout == 1'b0, "R6 reset dout", dout, 0);
    check(rx_valid == 1'b0, "R8 reset strobe", rx_valid, 0);
    check(mode == 1'b0, "R1 reset mode", mode, 0);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic test_mode_entry();
    run_frame(1, 0, 8'h5A, 8'h11, 0, 0, 0); // R1: one sync is not enough
    run_frame(1, 0, 8'hA5, 8'h3C, 1, 1, 0); // R1, R3: second sync enables slot one
  endtask

  task automatic test_slots();
    run_frame(1, 1, 8'h81, 8'hC3, 1, 1, 0); // R4: slot two
    run_frame(1, 0, 8'h00, 8'hFF, 1, 1, 0); // R5/R7 all-zero / all-one words
    run_frame(1, 1, 8'hFF, 8'h00, 1, 1, 0);
  endtask

  task automatic test_mode_exit();
    run_frame(1, 0, 8'h7E, 8'h96, 1, 1, 1); // R2: toggle mid-frame, frame completes
    run_frame(1, 0, 8'h42, 8'h24, 0, 0, 0); // R2: cleared at next sync
    run_frame(1, 0, 8'h42, 8'h24, 0, 0, 0); // R1: recount, one sync only
    run_frame(1, 1, 8'hB7, 8'h6D, 1, 1, 0); // R1: back on
  endtask

  task automatic test_no_sync();
    run_frame(0, 0, 8'hCC, 8'h33, 1, 0, 0); // R9: no sync, no transfer
    run_frame(0, 0, 8'hCC, 8'h33, 1, 0, 0); // R9: saturated index
    run_frame(1, 0, 8'h9C, 8'hE1, 1, 1, 0); // R3: sync returns
  endtask

  initial begin
    test_reset();
    test_mode_entry();
    test_slots();
    test_mode_exit();
    test_no_sync();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule